// File: doc/BRIEF.md
# Byte Operation ALU with Status Flags

This block is the combinational 8-bit datapath for operations that take a byte from the register file, combine it with the working register (W) and send the result back to one of the two. A 6-bit operation code selects one of seventeen functions: addition, four subtraction and step forms, bitwise logic, complement, move, four rotates and a nibble swap. The block returns the result, a write strobe for the working register or for the file register, the new status flags and a mask that marks which flags the operation updates.

Register addressing, bank selection and instruction sequencing sit outside. The caller decodes the instruction word, hands over the upper six bits as the operation code along with both operands, the destination bit and the current carry. It then commits the result and the masked flags in the same cycle.

Top module: `byte_alu`

## Requirements
- R1: The operation codes are: 001001 f+W, 001000 f+W+C, 001010 f+1 and 000001 f-1. All results are modulo 256.
- R2: The subtract codes are: 010111 f-W, 010110 f-W-(1-C) and 010101 W-f-(1-C). The carry out is the inverted borrow, so C=1 means that no borrow occurred.
- R3: For every defined code, exactly one write strobe is high: `w_we` when `dest_f`=0 and `f_we` when `dest_f`=1.
- R4: The flag vectors use bit 0=C, bit 1=DC, bit 2=Z, bit 3=OV and bit 4=N. Any bit of `flags_out` whose `flags_upd` bit is 0 reads 0.
- R5: The add, subtract, increment and decrement codes update all five flags. C is the carry out of bit 7 and DC is the carry out of bit 3, both as inverted borrow for subtraction. OV is the signed two's-complement overflow.
- R6: Whenever Z or N is updated, Z is 1 exactly when the result is 0, and N equals result bit 7.
- R7: The codes 000101 AND, 000100 OR, 000110 XOR, 000111 one's complement of f and 010100 move f update only Z and N (mask 10100).
- R8: 001101 rotates f left through carry, with C taking f[7]. 001100 rotates f right through carry, with C taking f[0]. Both update C, Z and N (mask 10101).
- R9: 010001 rotates f left and 010000 rotates f right without carry. Both update only Z and N (mask 10100).
- R10: 001110 swaps the two nibbles of f and updates no flag (mask 00000).
- R11: Any other code gives result 0, no write strobe, a zero update mask and zero flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Operation select (instruction bits 15..10) |
| w_val | input | 8 | Working register operand |
| f_val | input | 8 | File register operand |
| dest_f | input | 1 | Destination: 0 working register, 1 file register |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Operation result |
| w_we | output | 1 | Write strobe for the working register |
| f_we | output | 1 | Write strobe for the file register |
| flags_out | output | 5 | New flag values {N,OV,Z,DC,C}, masked |
| flags_upd | output | 5 | Flags this operation updates |

## Verification
The bench targets borrow polarity. Equal operands in f-W must give C=1 and DC=1; a design that used raw borrow would report C=0 there. Operand order is checked separately for the reversed subtract form. The with-borrow forms are run with C at both 0 and 1, which catches a design that adds the carry instead of subtracting its inverse. Signed overflow is checked at 7F+1, at 80-1 and at 80 decremented, because an OV computed from the uninverted operand fires on the wrong cases. Rotates are run with the carry at both values, which exposes a swapped carry source or direction, and undefined codes must leave both strobes and all masks low.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int NFLAG = 5;
  localparam int FL_C  = 0;
  localparam int FL_DC = 1;
  localparam int FL_Z  = 2;
  localparam int FL_OV = 3;
  localparam int FL_N  = 4;

  localparam logic [NFLAG-1:0] UPD_ALL  = 5'b11111;
  localparam logic [NFLAG-1:0] UPD_ZN   = 5'b10100;
  localparam logic [NFLAG-1:0] UPD_CZN  = 5'b10101;
  localparam logic [NFLAG-1:0] UPD_NONE = 5'b00000;

  // operation codes (bits 15..10 of the instruction word)
  localparam logic [5:0] OPC_ADD   = 6'b001001;
  localparam logic [5:0] OPC_ADDC  = 6'b001000;
  localparam logic [5:0] OPC_AND   = 6'b000101;
  localparam logic [5:0] OPC_OR    = 6'b000100;
  localparam logic [5:0] OPC_XOR   = 6'b000110;
  localparam logic [5:0] OPC_COM   = 6'b000111;
  localparam logic [5:0] OPC_DEC   = 6'b000001;
  localparam logic [5:0] OPC_INC   = 6'b001010;
  localparam logic [5:0] OPC_MOV   = 6'b010100;
  localparam logic [5:0] OPC_SUB   = 6'b010111;
  localparam logic [5:0] OPC_SUBB  = 6'b010110;
  localparam logic [5:0] OPC_RSUBB = 6'b010101;
  localparam logic [5:0] OPC_RLC   = 6'b001101;
  localparam logic [5:0] OPC_RL    = 6'b010001;
  localparam logic [5:0] OPC_RRC   = 6'b001100;
  localparam logic [5:0] OPC_RR    = 6'b010000;
  localparam logic [5:0] OPC_SWAP  = 6'b001110;

  // second adder operand
  typedef enum logic [2:0] {
    BSEL_W, BSEL_WN, BSEL_FN, BSEL_ONE, BSEL_ONES
  } bsel_e;

  // adder carry input
  typedef enum logic [1:0] {
    CIN_ZERO, CIN_ONE, CIN_CARRY
  } cin_e;

  // non-arithmetic function
  typedef enum logic [3:0] {
    BK_AND, BK_OR, BK_XOR, BK_NOT, BK_PASS,
    BK_RLC, BK_RL, BK_RRC, BK_RR, BK_SWAP
  } bk_e;

  typedef struct packed {
    logic             valid;
    logic             use_add;
    logic             a_is_w;
    bsel_e            bsel;
    cin_e             cin;
    bk_e              bk;
    logic             rot_c;
    logic [NFLAG-1:0] upd;
  } ctl_t;

endpackage

// File: rtl/byte_alu_decode.sv
module byte_alu_decode
  import byte_alu_pkg::*;
(
  input  logic [5:0] op_code,
  output ctl_t       ctl
);

  always_comb begin
    ctl         = '0;
    ctl.bsel    = BSEL_W;
    ctl.cin     = CIN_ZERO;
    ctl.bk      = BK_PASS;
    ctl.upd     = UPD_NONE;
    case (op_code)
      OPC_ADD: begin
        ctl.valid = 1'b1; ctl.use_add = 1'b1; ctl.upd = UPD_ALL;
      end
      OPC_ADDC: begin
        ctl.valid = 1'b1; ctl.use_add = 1'b1; ctl.cin = CIN_CARRY; ctl.upd = UPD_ALL;
      end
      OPC_INC: begin
        ctl.valid = 1'b1; ctl.use_add = 1'b1; ctl.bsel = BSEL_ONE; ctl.upd = UPD_ALL;
      end
      OPC_DEC: begin
        ctl.valid = 1'b1; ctl.use_add = 1'b1; ctl.bsel = BSEL_ONES; ctl.upd = UPD_ALL;
      end
      OPC_SUB: begin
        ctl.valid = 1'b1; ctl.use_add = 1'b1; ctl.bsel = BSEL_WN;
        ctl.cin = CIN_ONE; ctl.upd = UPD_ALL;
      end
      OPC_SUBB: begin
        ctl.valid = 1'b1; ctl.use_add = 1'b1; ctl.bsel = BSEL_WN;
        ctl.cin = CIN_CARRY; ctl.upd = UPD_ALL;
      end
      OPC_RSUBB: begin
        ctl.valid = 1'b1; ctl.use_add = 1'b1; ctl.a_is_w = 1'b1;
        ctl.bsel = BSEL_FN; ctl.cin = CIN_CARRY; ctl.upd = UPD_ALL;
      end
      OPC_AND: begin
        ctl.valid = 1'b1; ctl.bk = BK_AND; ctl.upd = UPD_ZN;
      end
      OPC_OR: begin
        ctl.valid = 1'b1; ctl.bk = BK_OR; ctl.upd = UPD_ZN;
      end
      OPC_XOR: begin
        ctl.valid = 1'b1; ctl.bk = BK_XOR; ctl.upd = UPD_ZN;
      end
      OPC_COM: begin
        ctl.valid = 1'b1; ctl.bk = BK_NOT; ctl.upd = UPD_ZN;
      end
      OPC_MOV: begin
        ctl.valid = 1'b1; ctl.bk = BK_PASS; ctl.upd = UPD_ZN;
      end
      OPC_RLC: begin
        ctl.valid = 1'b1; ctl.bk = BK_RLC; ctl.rot_c = 1'b1; ctl.upd = UPD_CZN;
      end
      OPC_RRC: begin
        ctl.valid = 1'b1; ctl.bk = BK_RRC; ctl.rot_c = 1'b1; ctl.upd = UPD_CZN;
      end
      OPC_RL: begin
        ctl.valid = 1'b1; ctl.bk = BK_RL; ctl.upd = UPD_ZN;
      end
      OPC_RR: begin
        ctl.valid = 1'b1; ctl.bk = BK_RR; ctl.upd = UPD_ZN;
      end
      OPC_SWAP: begin
        ctl.valid = 1'b1; ctl.bk = BK_SWAP; ctl.upd = UPD_NONE;
      end
      default: ctl.valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/byte_alu_adder.sv
module byte_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         dc_out,
  output logic         ov_out
);

  localparam int H  = W / 2;
  localparam int HU = W - H;

  logic [H:0]  lo_sum;
  logic [HU:0] hi_sum;

  always_comb begin
    lo_sum = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
    hi_sum = {1'b0, a[W-1:H]} + {1'b0, b[W-1:H]} + {{HU{1'b0}}, lo_sum[H]};
    sum    = {hi_sum[HU-1:0], lo_sum[H-1:0]};
    c_out  = hi_sum[HU];
    dc_out = lo_sum[H];
    ov_out = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  end

endmodule

// File: rtl/byte_alu_bitops.sv
module byte_alu_bitops
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  bk_e          bk,
  input  logic [W-1:0] w_in,
  input  logic [W-1:0] f_in,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         shout
);

  localparam int H = W / 2;

  logic [W-1:0] swapped;

  // nibble exchange, one bit per iteration
  for (genvar i = 0; i < W; i++) begin : g_swap
    if (i < W - H) begin : g_lo
      assign swapped[i] = f_in[i + H];
    end else begin : g_hi
      assign swapped[i] = f_in[i - (W - H)];
    end
  end

  always_comb begin
    res   = f_in;
    shout = 1'b0;
    case (bk)
      BK_AND:  res = w_in & f_in;
      BK_OR:   res = w_in | f_in;
      BK_XOR:  res = w_in ^ f_in;
      BK_NOT:  res = ~f_in;
      BK_PASS: res = f_in;
      BK_RLC: begin
        res   = {f_in[W-2:0], cin};
        shout = f_in[W-1];
      end
      BK_RL:   res = {f_in[W-2:0], f_in[W-1]};
      BK_RRC: begin
        res   = {cin, f_in[W-1:1]};
        shout = f_in[0];
      end
      BK_RR:   res = {f_in[0], f_in[W-1:1]};
      BK_SWAP: res = swapped;
      default: res = f_in;
    endcase
  end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [5:0]       op_code,
  input  logic [W-1:0]     w_val,
  input  logic [W-1:0]     f_val,
  input  logic             dest_f,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic             w_we,
  output logic             f_we,
  output logic [NFLAG-1:0] flags_out,
  output logic [NFLAG-1:0] flags_upd
);

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ONES = {W{1'b1}};

  ctl_t         ctl;
  logic [W-1:0] add_a;
  logic [W-1:0] add_b;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_c;
  logic         add_dc;
  logic         add_ov;
  logic [W-1:0] bit_res;
  logic         bit_sh;
  logic [W-1:0] res_raw;
  logic [NFLAG-1:0] flg_raw;

  byte_alu_decode u_dec (
    .op_code (op_code),
    .ctl     (ctl)
  );

  always_comb begin
    add_a = ctl.a_is_w ? w_val : f_val;
    case (ctl.bsel)
      BSEL_W:    add_b = w_val;
      BSEL_WN:   add_b = ~w_val;
      BSEL_FN:   add_b = ~f_val;
      BSEL_ONE:  add_b = ONE;
      BSEL_ONES: add_b = ONES;
      default:   add_b = w_val;
    endcase
    case (ctl.cin)
      CIN_ONE:   add_cin = 1'b1;
      CIN_CARRY: add_cin = carry_in;
      default:   add_cin = 1'b0;
    endcase
  end

  byte_alu_adder #(.W(W)) u_add (
    .a      (add_a),
    .b      (add_b),
    .cin    (add_cin),
    .sum    (add_sum),
    .c_out  (add_c),
    .dc_out (add_dc),
    .ov_out (add_ov)
  );

  byte_alu_bitops #(.W(W)) u_bit (
    .bk    (ctl.bk),
    .w_in  (w_val),
    .f_in  (f_val),
    .cin   (carry_in),
    .res   (bit_res),
    .shout (bit_sh)
  );

  always_comb begin
    res_raw = ctl.use_add ? add_sum : bit_res;
    flg_raw          = '0;
    flg_raw[FL_C]    = ctl.use_add ? add_c : bit_sh;
    flg_raw[FL_DC]   = add_dc;
    flg_raw[FL_OV]   = add_ov;
    flg_raw[FL_Z]    = (res_raw == '0);
    flg_raw[FL_N]    = res_raw[W-1];

    result    = ctl.valid ? res_raw : '0;
    w_we      = ctl.valid && !dest_f;
    f_we      = ctl.valid && dest_f;
    flags_upd = ctl.valid ? ctl.upd : UPD_NONE;
    flags_out = flg_raw & flags_upd;
  end

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic [5:0]       op_code,
  input logic [W-1:0]     w_val,
  input logic [W-1:0]     f_val,
  input logic             dest_f,
  input logic             carry_in,
  input logic [W-1:0]     result,
  input logic             w_we,
  input logic             f_we,
  input logic [NFLAG-1:0] flags_out,
  input logic [NFLAG-1:0] flags_upd
);

  logic [W-1:0] unused_mix;
  assign unused_mix = w_val ^ f_val ^ {{(W-6){1'b0}}, op_code} ^ {{(W-1){1'b0}}, carry_in};

  always_comb begin
    // R3
    we_excl_chk: assert (!(w_we && f_we));
    // R3
    dest_route_chk: assert (!(w_we || f_we) || (f_we == dest_f));
    // R4
    masked_zero_chk: assert ((flags_out & ~flags_upd) == '0);
    // R6
    zero_flag_chk: assert (!flags_upd[FL_Z] || (flags_out[FL_Z] == (result == '0)));
    // R6
    neg_flag_chk: assert (!flags_upd[FL_N] || (flags_out[FL_N] == result[W-1]));
    // R11
    idle_quiet_chk: assert ((w_we || f_we) || (flags_upd == '0 && result == '0));
  end

endmodule

bind byte_alu byte_alu_chk #(.W(W)) u_chk (
  .op_code   (op_code),
  .w_val     (w_val),
  .f_val     (f_val),
  .dest_f    (dest_f),
  .carry_in  (carry_in),
  .result    (result),
  .w_we      (w_we),
  .f_we      (f_we),
  .flags_out (flags_out),
  .flags_upd (flags_upd)
);

// File: tb/byte_alu_bench.sv
module byte_alu_bench;

  logic       clk;
  logic       rst_n;
  logic [5:0] op_code;
  logic [7:0] w_val;
  logic [7:0] f_val;
  logic       dest_f;
  logic       carry_in;
  logic [7:0] result;
  logic       w_we;
  logic       f_we;
  logic [4:0] flags_out;
  logic [4:0] flags_upd;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic finished = 1'b0;

  byte_alu u_byte_alu (
    .op_code   (op_code),
    .w_val     (w_val),
    .f_val     (f_val),
    .dest_f    (dest_f),
    .carry_in  (carry_in),
    .result    (result),
    .w_we      (w_we),
    .f_we      (f_we),
    .flags_out (flags_out),
    .flags_upd (flags_upd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !finished) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic apply(input logic [5:0] op, input logic [7:0] w, input logic [7:0] f,
                       input logic d, input logic c);
    @(negedge clk);
    op_code = op; w_val = w; f_val = f; dest_f = d; carry_in = c;
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] e_res, input logic e_wwe,
                       input logic e_fwe, input logic [4:0] e_flg, input logic [4:0] e_upd);
    total = total + 1;
    if (result !== e_res || w_we !== e_wwe || f_we !== e_fwe ||
        flags_out !== e_flg || flags_upd !== e_upd) begin
      bad = bad + 1;
      $display("FAIL %s op=%b: got res=%h w=%b f=%b flg=%b upd=%b, exp res=%h w=%b f=%b flg=%b upd=%b",
               req, op_code, result, w_we, f_we, flags_out, flags_upd,
               e_res, e_wwe, e_fwe, e_flg, e_upd);
    end
  endtask

  task automatic t_idle();
    apply(6'b000000, 8'h00, 8'h00, 1'b0, 1'b0);
    check("R11 idle", 8'h00, 0, 0, 5'b00000, 5'b00000);
  endtask

  task automatic t_add();
    apply(6'b001001, 8'h01, 8'h7F, 1'b1, 1'b0);
    check("R1 R5 add 7F+1", 8'h80, 0, 1, 5'b11010, 5'b11111);
    apply(6'b001001, 8'h01, 8'hFF, 1'b0, 1'b0);
    check("R1 R5 R6 add FF+1", 8'h00, 1, 0, 5'b00111, 5'b11111);
    apply(6'b001000, 8'h10, 8'h20, 1'b1, 1'b1);
    check("R1 addc", 8'h31, 0, 1, 5'b00000, 5'b11111);
    apply(6'b001010, 8'h00, 8'hFF, 1'b1, 1'b0);
    check("R1 inc FF", 8'h00, 0, 1, 5'b00111, 5'b11111);
    apply(6'b000001, 8'h00, 8'h00, 1'b0, 1'b1);
    check("R1 dec 00", 8'hFF, 1, 0, 5'b10000, 5'b11111);
    apply(6'b000001, 8'h00, 8'h80, 1'b0, 1'b0);
    check("R1 R5 dec 80", 8'h7F, 1, 0, 5'b01001, 5'b11111);
  endtask

  task automatic t_sub();
    apply(6'b010111, 8'h05, 8'h05, 1'b1, 1'b0);
    check("R2 sub equal", 8'h00, 0, 1, 5'b00111, 5'b11111);
    apply(6'b010111, 8'h05, 8'h03, 1'b0, 1'b1);
    check("R2 sub borrow", 8'hFE, 1, 0, 5'b10000, 5'b11111);
    apply(6'b010111, 8'h01, 8'h80, 1'b0, 1'b0);
    check("R2 R5 sub ovf", 8'h7F, 1, 0, 5'b01001, 5'b11111);
    apply(6'b010110, 8'h05, 8'h05, 1'b1, 1'b0);
    check("R2 subb c0", 8'hFF, 0, 1, 5'b10000, 5'b11111);
    apply(6'b010110, 8'h05, 8'h05, 1'b1, 1'b1);
    check("R2 subb c1", 8'h00, 0, 1, 5'b00111, 5'b11111);
    apply(6'b010101, 8'h10, 8'h01, 1'b0, 1'b1);
    check("R2 rsubb", 8'h0F, 1, 0, 5'b00001, 5'b11111);
  endtask

  task automatic t_logic();
    apply(6'b000101, 8'hF0, 8'h3C, 1'b1, 1'b1);
    check("R7 and", 8'h30, 0, 1, 5'b00000, 5'b10100);
    apply(6'b000100, 8'h00, 8'h00, 1'b0, 1'b1);
    check("R7 R6 or zero", 8'h00, 1, 0, 5'b00100, 5'b10100);
    apply(6'b000110, 8'h0F, 8'hF0, 1'b0, 1'b0);
    check("R7 xor", 8'hFF, 1, 0, 5'b10000, 5'b10100);
    apply(6'b000111, 8'h00, 8'hFF, 1'b1, 1'b1);
    check("R7 com", 8'h00, 0, 1, 5'b00100, 5'b10100);
    apply(6'b010100, 8'h00, 8'h85, 1'b0, 1'b1);
    check("R7 R3 move", 8'h85, 1, 0, 5'b10000, 5'b10100);
  endtask

  task automatic t_rotate();
    apply(6'b001101, 8'h00, 8'h81, 1'b1, 1'b0);
    check("R8 rlc", 8'h02, 0, 1, 5'b00001, 5'b10101);
    apply(6'b001100, 8'h00, 8'h01, 1'b1, 1'b1);
    check("R8 rrc c1", 8'h80, 0, 1, 5'b10001, 5'b10101);
    apply(6'b001100, 8'h00, 8'h01, 1'b0, 1'b0);
    check("R8 rrc c0", 8'h00, 1, 0, 5'b00101, 5'b10101);
    apply(6'b010001, 8'h00, 8'h81, 1'b1, 1'b0);
    check("R9 rl", 8'h03, 0, 1, 5'b00000, 5'b10100);
    apply(6'b010000, 8'h00, 8'h01, 1'b0, 1'b0);
    check("R9 rr", 8'h80, 1, 0, 5'b10000, 5'b10100);
  endtask

  task automatic t_swap();
    apply(6'b001110, 8'h00, 8'hA5, 1'b1, 1'b1);
    check("R10 swap", 8'h5A, 0, 1, 5'b00000, 5'b00000);
    apply(6'b001110, 8'h00, 8'h00, 1'b0, 1'b1);
    check("R10 R4 swap zero", 8'h00, 1, 0, 5'b00000, 5'b00000);
  endtask

  task automatic t_unused();
    apply(6'b111111, 8'hFF, 8'hFF, 1'b1, 1'b1);
    check("R11 code 3F", 8'h00, 0, 0, 5'b00000, 5'b00000);
    apply(6'b011000, 8'h12, 8'h34, 1'b0, 1'b0);
    check("R11 code 18", 8'h00, 0, 0, 5'b00000, 5'b00000);
  endtask

  initial begin
    rst_n = 1'b0;
    op_code = '0; w_val = '0; f_val = '0; dest_f = 1'b0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_rotate();
    t_swap();
    t_unused();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule